// File: doc/BRIEF.md
# Edge-Interval Bit-Check Validator

This block decides whether a demodulated serial preamble is clean enough for a receiver to switch into receive mode. When enabled, it first sits through a start-up interval in which the demodulator output is not trusted and is ignored. It then measures the spacing between successive edges of the data input. The measure is a count of ticks from a time-base strobe, and each count is compared against programmable lower and upper limits.

An interval is accepted when its tick count lies between the lower limit and one less than the upper limit. A programmed number of consecutive accepted intervals raises a pass level, which holds until enable is dropped. An edge that comes too early fails the check at once. The check also fails, without waiting for an edge, the moment the running count reaches the upper limit. Each failure gives a one-clock fail pulse and restarts the count of good intervals. Start-up is not repeated.

Top module: `bitchk_validator`

## Requirements
- R1: For STARTUP_TICKS ticks after enable rises, data edges are ignored: they produce neither fail nor pass and do not start an interval.
- R2: A data edge is a change of the synchronized input in either direction. The first edge after start-up, or after an upper-limit failure, opens an interval without evaluating anything. The interval counter then advances once per tick and restarts at every edge.
- R3: An edge whose count is below the lower limit gives a fail pulse of one clock and clears the good-interval count. That same edge opens the next interval.
- R4: When the count reaches the upper limit with no edge, fail pulses on the next clock. The block then waits for the next edge to open a fresh interval, and gives no further fail while the data input stays quiet.
- R5: The accepted window is lower limit to upper limit − 1 ticks inclusive. With limits 14 and 24, intervals of 14 and 23 ticks pass, while intervals of 13 and 24 ticks fail.
- R6: The 2-bit count select sets the number of consecutive good intervals needed: code 0 needs 3, code 1 needs 6, code 2 needs 9, and the reserved code 3 also needs 9. Pass rises on exactly that interval and not before.
- R7: Pass is a level that holds while enable stays high. Once pass is set, edges are no longer evaluated and fail stays low.
- R8: Dropping enable returns the block to idle on the next clock, with pass and busy low. Raising enable again repeats start-up.
- R9: Busy is high from the clock after enable rises until pass is set. Busy and pass are never high together.
- R10: After reset, pass, fail and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables the validator; low forces idle |
| tick | input | 1 | Time-base strobe, one clock wide |
| din | input | 1 | Demodulated data, asynchronous |
| lim_lo | input | 6 | Lower interval limit in ticks |
| lim_hi | input | 6 | Upper interval limit in ticks (failure when reached) |
| cnt_sel | input | 2 | Count select: 0→3, 1→6, 2 or 3→9 intervals |
| pass | output | 1 | Preamble accepted (level) |
| fail | output | 1 | One-clock pulse per failed interval |
| busy | output | 1 | Start-up or bit check in progress |

## Verification
The assertions check the following on every cycle:
- pass holds while enable stays high;
- pass and fail never occur together;
- enable low forces idle;
- start-up produces no fail;
- a count at the upper limit is always followed by a fail pulse.

Only the bench's scenarios can show the rest, because each depends on whole sequences of spaced edges:
- the exact edges of the acceptance window;
- that pass comes on exactly the selected interval and not earlier;
- that edges during start-up are ignored;
- that a failure restarts the check without a second start-up.

// File: rtl/bitchk_pkg.sv
package bitchk_pkg;

    localparam int CNT_W  = 6;
    localparam int PASS_W = 4;

    localparam int NEED_SHORT = 3;
    localparam int NEED_MID   = 6;
    localparam int NEED_LONG  = 9;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_STARTUP = 3'd1,
        PH_ARM     = 3'd2,
        PH_CHECK   = 3'd3,
        PH_DONE    = 3'd4
    } phase_e;

    // Number of good intervals demanded by the select code; reserved code maps to the longest.
    function automatic logic [PASS_W-1:0] need_from_sel(input logic [1:0] sel);
        case (sel)
            2'd0:    need_from_sel = PASS_W'(NEED_SHORT);
            2'd1:    need_from_sel = PASS_W'(NEED_MID);
            default: need_from_sel = PASS_W'(NEED_LONG);
        endcase
    endfunction

endpackage

// File: rtl/bitchk_edge_sync.sv
module bitchk_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_seen
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_seen = sync_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/bitchk_tick_counter.sv
module bitchk_tick_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)               cnt <= '0;
        else if (tick && cnt != TOP)  cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/bitchk_ctrl.sv
module bitchk_ctrl
    import bitchk_pkg::*;
#(
    parameter int STARTUP_TICKS = 8,
    parameter int SU_W          = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             edge_seen,
    input  logic [CNT_W-1:0] ivl_cnt,
    input  logic [SU_W-1:0]  su_cnt,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [1:0]       cnt_sel,
    output logic             ivl_clr,
    output logic             su_clr,
    output phase_e           phase,
    output logic             fail_q
);
    localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_TICKS - 1);

    phase_e            ph_d;
    logic [PASS_W-1:0] good_q, good_d;
    logic              fail_d;
    logic [PASS_W-1:0] need;

    assign need = need_from_sel(cnt_sel);

    always_comb begin
        ph_d    = phase;
        good_d  = good_q;
        fail_d  = 1'b0;
        ivl_clr = 1'b1;
        su_clr  = 1'b0;
        if (!en) begin
            ph_d   = PH_IDLE;
            good_d = '0;
            su_clr = 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    ph_d   = PH_STARTUP;
                    su_clr = 1'b1;
                end
                PH_STARTUP: begin
                    if (tick && su_cnt == SU_LAST) ph_d = PH_ARM;
                end
                PH_ARM: begin
                    good_d = '0;
                    if (edge_seen) ph_d = PH_CHECK;
                end
                PH_CHECK: begin
                    if (ivl_cnt >= lim_hi) begin
                        fail_d = 1'b1;
                        good_d = '0;
                        ph_d   = PH_ARM;
                    end else if (edge_seen) begin
                        if (ivl_cnt < lim_lo) begin
                            fail_d = 1'b1;
                            good_d = '0;
                        end else if (good_q + 1'b1 >= need) begin
                            ph_d = PH_DONE;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end else begin
                        ivl_clr = 1'b0;
                    end
                end
                PH_DONE: ph_d = PH_DONE;
                default: ph_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            good_q <= '0;
            fail_q <= 1'b0;
        end else begin
            phase  <= ph_d;
            good_q <= good_d;
            fail_q <= fail_d;
        end
    end

endmodule

// File: rtl/bitchk_validator.sv
module bitchk_validator
    import bitchk_pkg::*;
#(
    parameter int STARTUP_TICKS = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             din,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [1:0]       cnt_sel,
    output logic             pass,
    output logic             fail,
    output logic             busy
);
    localparam int SU_W = $clog2(STARTUP_TICKS + 1);

    logic             edge_seen;
    logic             ivl_clr;
    logic             su_clr;
    logic [CNT_W-1:0] ivl_cnt;
    logic [SU_W-1:0]  su_cnt;
    phase_e           phase;

    bitchk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .edge_seen (edge_seen)
    );

    bitchk_tick_counter #(.W(CNT_W)) u_ivl (
        .clk  (clk),
        .rst  (rst),
        .clr  (ivl_clr),
        .tick (tick),
        .cnt  (ivl_cnt)
    );

    bitchk_tick_counter #(.W(SU_W)) u_su (
        .clk  (clk),
        .rst  (rst),
        .clr  (su_clr),
        .tick (tick),
        .cnt  (su_cnt)
    );

    bitchk_ctrl #(.STARTUP_TICKS(STARTUP_TICKS), .SU_W(SU_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tick      (tick),
        .edge_seen (edge_seen),
        .ivl_cnt   (ivl_cnt),
        .su_cnt    (su_cnt),
        .lim_lo    (lim_lo),
        .lim_hi    (lim_hi),
        .cnt_sel   (cnt_sel),
        .ivl_clr   (ivl_clr),
        .su_clr    (su_clr),
        .phase     (phase),
        .fail_q    (fail)
    );

    assign pass = (phase == PH_DONE);
    assign busy = (phase == PH_STARTUP) || (phase == PH_ARM) || (phase == PH_CHECK);

endmodule

// File: rtl/bitchk_validator_chk.sv
module bitchk_validator_chk
    import bitchk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [CNT_W-1:0] lim_hi,
    input logic             pass,
    input logic             fail,
    input logic             busy,
    input phase_e           phase,
    input logic [CNT_W-1:0] ivl_cnt
);
    // R7
    pass_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pass && en) |=> pass);

    // R7
    pass_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    // R8
    idle_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pass && !busy));

    // R1
    startup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STARTUP && $past(phase) == PH_STARTUP) |-> !fail);

    // R4
    overflow_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (en && phase == PH_CHECK && ivl_cnt >= lim_hi) |=> fail);

    // R9
    busy_pass_excl_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !pass);

endmodule

bind bitchk_validator bitchk_validator_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .lim_hi  (lim_hi),
    .pass    (pass),
    .fail    (fail),
    .busy    (busy),
    .phase   (phase),
    .ivl_cnt (ivl_cnt)
);

// File: tb/bitchk_validator_tb_top.sv
`timescale 1ns/1ps
module bitchk_validator_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       din = 1'b0;
    logic [5:0] lim_lo = 6'd14;
    logic [5:0] lim_hi = 6'd24;
    logic [1:0] cnt_sel = 2'd1;
    logic       pass, fail, busy;

    int checks = 0;
    int errors = 0;
    int fail_seen = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bitchk_validator dut_i (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .din(din),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .cnt_sel(cnt_sel),
        .pass(pass), .fail(fail), .busy(busy)
    );

    always @(negedge clk) if (!rst && fail) fail_seen++;

    // vector: lo[20:15] hi[14:9] sel[8:7] interval[6:1] expect_pass[0]
    localparam int NV = 8;
    localparam logic [20:0] VECS [NV] = '{
        {6'd14, 6'd24, 2'd1, 6'd14, 1'b1},   // R5 low edge of window
        {6'd14, 6'd24, 2'd1, 6'd23, 1'b1},   // R5 high edge of window
        {6'd14, 6'd24, 2'd1, 6'd13, 1'b0},   // R3 R5 too short
        {6'd14, 6'd24, 2'd1, 6'd24, 1'b0},   // R4 R5 reaches upper limit
        {6'd10, 6'd20, 2'd0, 6'd10, 1'b1},   // R6 three intervals
        {6'd10, 6'd20, 2'd2, 6'd15, 1'b1},   // R6 nine intervals
        {6'd14, 6'd24, 2'd3, 6'd20, 1'b1},   // R6 reserved code
        {6'd20, 6'd63, 2'd0, 6'd62, 1'b1}    // R2 long interval
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One time-base period of four clocks; tick on the first, optional data toggle with it.
    task automatic period(input bit tg);
        @(negedge clk);
        tick = 1'b1;
        if (tg) din = ~din;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) period(1'b0);
    endtask

    // Arm edge then n intervals of k ticks each.
    task automatic send(input int k, input int n);
        period(1'b1);
        for (int i = 0; i < n; i++) begin
            idle(k - 1);
            period(1'b1);
        end
    endtask

    task automatic restart(input logic [5:0] lo, input logic [5:0] hi, input logic [1:0] sel);
        @(negedge clk);
        en = 1'b0;
        lim_lo = lo; lim_hi = hi; cnt_sel = sel;
        idle(1);
        en = 1'b1;
        idle(12);
        fail_seen = 0;
    endtask

    function automatic int need_of(input logic [1:0] sel);
        return (sel == 2'd0) ? 3 : (sel == 2'd1) ? 6 : 9;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        check(!pass && !fail && !busy, "R10", {pass, fail, busy}, 0);
        rst = 1'b0;
        idle(1);
        check(!busy, "R10", busy, 0);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [20:0] e;
            int need;
            e = VECS[v];
            need = need_of(e[8:7]);
            restart(e[20:15], e[14:9], e[8:7]);
            send(int'(e[6:1]), need);
            idle(2);
            check(pass == e[0], e[0] ? "R5" : "R3", pass, e[0]);
            check(fail_seen == (e[0] ? 0 : need), "R4", fail_seen, e[0] ? 0 : need);
        end

        // R6 exact count: two intervals are not enough, the third passes
        restart(6'd10, 6'd20, 2'd0);
        send(12, 2);
        idle(2);
        check(!pass && busy, "R6", pass, 0);
        idle(9);
        period(1'b1);
        idle(2);
        check(pass, "R6", pass, 1);

        // R6 reserved code needs nine, not eight
        restart(6'd10, 6'd20, 2'd3);
        send(12, 8);
        idle(2);
        check(!pass, "R6", pass, 0);

        // R4 overflow without edge: fail once, then quiet until an edge
        restart(6'd14, 6'd24, 2'd1);
        period(1'b1);
        idle(23);
        check(fail_seen == 0, "R4", fail_seen, 0);
        idle(2);
        check(fail_seen == 1, "R4", fail_seen, 1);
        idle(30);
        check(fail_seen == 1 && busy, "R4", fail_seen, 1);

        // R3 failing edge opens the next interval; no new start-up needed
        restart(6'd10, 6'd20, 2'd0);
        period(1'b1);
        idle(4);
        period(1'b1);
        for (int i = 0; i < 3; i++) begin
            idle(11);
            period(1'b1);
        end
        idle(2);
        check(fail_seen == 1, "R3", fail_seen, 1);
        check(pass, "R3", pass, 1);

        // R7 after pass, short intervals are not evaluated
        fail_seen = 0;
        for (int i = 0; i < 6; i++) period(1'b1);
        idle(2);
        check(pass && fail_seen == 0, "R7", fail_seen, 0);
        check(!busy, "R9", busy, 0);

        // R8 disable clears pass and busy next clock
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!pass && !busy, "R8", {pass, busy}, 0);

        // R1 edges during start-up are ignored; R9 busy after enable
        idle(1);
        lim_lo = 6'd10; lim_hi = 6'd20; cnt_sel = 2'd0;
        fail_seen = 0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check(busy, "R9", busy, 1);
        for (int i = 0; i < 6; i++) period(1'b1);
        idle(6);
        check(fail_seen == 0 && !pass && busy, "R1", fail_seen, 0);
        send(12, 3);
        idle(2);
        check(pass && fail_seen == 0, "R1", pass, 1);

        finish_run();
    end

endmodule